// File: doc/BRIEF.md
# Watchdog Timer with Keyed Refresh

This block is a supervisory timer for a processor subsystem. A fixed divide-by-four prescaler drives a 24-bit down-counter. Once the watchdog is armed, software must refresh it at regular intervals. A refresh is a two-byte key: 0xAA and then 0x55, written to the refresh register. If the counter drains to zero, the block records a sticky timeout flag. If the timeout reset is enabled, it also raises a one-cycle reset request. A malformed key on an enabled watchdog raises the reset request at once.

Software reaches the block through single-cycle register reads and writes. A read is combinational and returns data in the cycle that `rd_en` is high. A write takes effect at the clock edge on which `wr_en` is sampled high. There is no stream traffic and no back-pressure: every access completes in one cycle.

Register offsets, on the 4-bit `addr`:
- 0x0: control.
- 0x4: reload value.
- 0x8: refresh key.
- 0xC: live count, read-only.

Control register fields:
- Bit 0: enable.
- Bit 1: timeout-reset enable.
- Bit 2: timeout flag, read-only and sticky.

Setting the enable bit does not arm the watchdog on its own. The watchdog arms on the first valid key that completes while enable is set.

Top module: `wdg_timer`

## Requirements
- R1: After reset, control (0x0) reads 0, reload value (0x4) reads 0xFF, live count (0xC) reads 0xFFFFFF, and `wdg_rst_o` is low.
- R2: A write to 0x4 stores bits [23:0] of `wdata`. A value below 0xFF is stored as 0xFF. Bits [31:24] read back as 0.
- R3: Control bit 0 (enable) is set by writing 1. Writing 0 to it leaves it at 1. Control bit 1 follows each write to 0x0.
- R4: A write of 0xAA to 0x8, directly followed by a write of 0x55 to 0x8, loads the live count from the reload value at the edge of the 0x55 write.
- R5: Until a valid key completes while enable is set, the live count does not change except by a key load, and no timeout occurs.
- R6: Once armed, the live count drops by one every 4 clocks. N clocks after a key load it reads reload − floor(N/4), and it stops at 0.
- R7: When an armed count reaches 0 with control bit 1 set, `wdg_rst_o` is high for exactly one cycle. That cycle is 4×reload clocks after the key load, and control bit 2 becomes 1 in the same cycle.
- R8: When an armed count reaches 0 with control bit 1 clear, control bit 2 is set and `wdg_rst_o` stays low.
- R9: With enable set, a write of 0xAA to 0x8 followed by any other value written to 0x8 raises `wdg_rst_o` for one cycle, in the cycle after that write. With enable clear, the same sequence has no effect on `wdg_rst_o`.
- R10: Any read, or any write to an address other than 0x8, between the two key bytes abandons the key without a load or a reset. A fresh 0xAA, 0x55 pair then works.
- R11: A valid key while enable is clear loads the count but does not arm the watchdog, so the count then holds.
- R12: `wdg_rst_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while rd_en is high, else 0 |
| wdg_rst_o | output | 1 | One-cycle reset request |

## Verification
The following invariants are checked on every cycle:
- The enable bit never falls.
- An unarmed count holds.
- An armed count never moves by more than one step per cycle.
- A key load copies the reload value.
- The timeout flag rises only together with a zero count.
- The reset request never lasts two cycles.
- A malformed key on an enabled watchdog is followed by the request.

Only the bench scenarios can show the exact expiry cycle of 4×reload clocks, the reload clamping across a sweep of written values, and the count value a given number of clocks after a key. They also cover the effect of key abandonment on a later key, and the difference between an enabled and a disabled watchdog.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam logic [3:0] OFS_CTRL   = 4'h0;
  localparam logic [3:0] OFS_RELOAD = 4'h4;
  localparam logic [3:0] OFS_KEY    = 4'h8;
  localparam logic [3:0] OFS_COUNT  = 4'hC;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;

  localparam int CTRL_EN    = 0;
  localparam int CTRL_RSTEN = 1;
  localparam int CTRL_FLAG  = 2;

  typedef enum logic {
    KEY_IDLE,
    KEY_HALF
  } key_state_t;
endpackage

// File: rtl/wdg_key_seq.sv
module wdg_key_seq
  import wdg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic       other_acc,
  input  logic [7:0] key_byte,
  output logic       key_ok,
  output logic       key_bad
);
  key_state_t st_q, st_d;

  always_comb begin
    key_ok  = 1'b0;
    key_bad = 1'b0;
    st_d    = st_q;
    unique case (st_q)
      KEY_IDLE: begin
        if (key_wr && key_byte == KEY_FIRST) st_d = KEY_HALF;
      end
      KEY_HALF: begin
        if (key_wr) begin
          key_ok  = (key_byte == KEY_SECOND);
          key_bad = (key_byte != KEY_SECOND);
          st_d    = KEY_IDLE;
        end else if (other_acc) begin
          st_d = KEY_IDLE;
        end
      end
      default: st_d = KEY_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= KEY_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] ph_q;

  assign tick = run && !clear && (ph_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ph_q <= '0;
    else if (clear)          ph_q <= '0;
    else if (run) begin
      if (ph_q == LAST)      ph_q <= '0;
      else                   ph_q <= ph_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdg_down_counter.sv
module wdg_down_counter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [W-1:0] value,
  output logic         expire
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] val_q;

  assign value  = val_q;
  assign expire = step && !load && (val_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      val_q <= '1;
    else if (load)                   val_q <= load_val;
    else if (step && val_q != '0)    val_q <= val_q - ONE;
  end
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
  import wdg_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32,
  parameter int PRESC  = 4,
  parameter int TC_MIN = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [3:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              wdg_rst_o
);
  localparam logic [CNT_W-1:0] FLOOR = CNT_W'(TC_MIN);

  logic             en_q, rsten_q, flag_q, armed_q, rst_q;
  logic [CNT_W-1:0] tc_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] tc_in;
  logic             key_wr, other_acc, key_ok, key_bad, tick, expire;

  assign key_wr    = wr_en && (addr == OFS_KEY);
  assign other_acc = (wr_en || rd_en) && !key_wr;
  assign tc_in     = wdata[CNT_W-1:0];

  wdg_key_seq u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (key_wr),
    .other_acc(other_acc),
    .key_byte (wdata[7:0]),
    .key_ok   (key_ok),
    .key_bad  (key_bad)
  );

  wdg_prescaler #(.DIV(PRESC)) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (armed_q),
    .clear(key_ok),
    .tick (tick)
  );

  wdg_down_counter #(.W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (key_ok),
    .load_val(tc_q),
    .step    (tick),
    .value   (cnt),
    .expire  (expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      rsten_q <= 1'b0;
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
      rst_q   <= 1'b0;
      tc_q    <= FLOOR;
    end else begin
      if (wr_en && addr == OFS_CTRL) begin
        en_q    <= en_q | wdata[CTRL_EN];
        rsten_q <= wdata[CTRL_RSTEN];
      end
      if (wr_en && addr == OFS_RELOAD)
        tc_q <= (tc_in < FLOOR) ? FLOOR : tc_in;
      if (key_ok && en_q) armed_q <= 1'b1;
      if (expire)         flag_q  <= 1'b1;
      rst_q <= !rst_q && ((expire && rsten_q) || (key_bad && en_q));
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (addr)
        OFS_CTRL: begin
          rdata[CTRL_EN]    = en_q;
          rdata[CTRL_RSTEN] = rsten_q;
          rdata[CTRL_FLAG]  = flag_q;
        end
        OFS_RELOAD: rdata = DATA_W'(tc_q);
        OFS_COUNT:  rdata = DATA_W'(cnt);
        default:    rdata = '0;
      endcase
    end
  end

  assign wdg_rst_o = rst_q;
endmodule

// File: rtl/wdg_timer_chk.sv
module wdg_timer_chk #(
  parameter int CNT_W  = 24,
  parameter int TC_MIN = 255
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             armed,
  input logic             flag,
  input logic             key_ok,
  input logic             key_bad,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] tc,
  input logic             rst_o
);
  a_r2_tc_floor: assert property (@(posedge clk) disable iff (!rst_n)
    tc >= CNT_W'(TC_MIN));

  a_r3_en_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> en);

  a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
    key_ok |=> cnt == $past(tc));

  a_r5_hold_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !key_ok) |=> $stable(cnt));

  a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !key_ok) |=> (cnt == $past(cnt) || cnt == $past(cnt) - 1'b1));

  a_r7_flag_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> cnt == '0);

  a_r9_bad_key: assert property (@(posedge clk) disable iff (!rst_n)
    (key_bad && en && !rst_o) |=> rst_o);

  a_r12_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_o |=> !rst_o);
endmodule

bind wdg_timer wdg_timer_chk #(.CNT_W(CNT_W), .TC_MIN(TC_MIN)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .en     (en_q),
  .armed  (armed_q),
  .flag   (flag_q),
  .key_ok (key_ok),
  .key_bad(key_bad),
  .cnt    (cnt),
  .tc     (tc_q),
  .rst_o  (wdg_rst_o)
);

// File: tb/wdg_timer_bench.sv
module wdg_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = 4'h0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        wdg_rst_o;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wdg_timer u_wdg_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .wdg_rst_o(wdg_rst_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic key(input logic [7:0] second);
    wr(4'h8, 32'hAA);
    wr(4'h8, {24'h0, second});
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] tcs [3];
    logic [31:0] writes [7];
    int first, width;

    // R1 reset state
    do_reset();
    chk("R1 rst_o", {31'b0, wdg_rst_o}, 32'h0);
    rd(4'h0, v); chk("R1 ctrl", v, 32'h0);
    rd(4'h4, v); chk("R1 reload", v, 32'hFF);
    rd(4'hC, v); chk("R1 count", v, 32'hFFFFFF);

    // R2 reload clamp sweep
    writes = '{32'h0, 32'h1, 32'hFE, 32'hFF, 32'h100, 32'hFFFFFF, 32'hFF123456};
    foreach (writes[i]) begin
      logic [31:0] e;
      e = writes[i] & 32'hFFFFFF;
      if (e < 32'hFF) e = 32'hFF;
      wr(4'h4, writes[i]);
      rd(4'h4, v); chk("R2 reload clamp", v, e);
    end

    // R5 enabled but no key: count holds, no timeout
    do_reset();
    wr(4'h0, 32'h3);
    first = 0;
    for (int j = 0; j < 1200; j++) begin
      @(negedge clk);
      if (wdg_rst_o) first++;
    end
    chk("R5 no reset while unarmed", first, 0);
    rd(4'hC, v); chk("R5 count held", v, 32'hFFFFFF);
    rd(4'h0, v); chk("R5 no flag", v, 32'h3);

    // R3 enable sticky, bit1 follows
    wr(4'h0, 32'h0);
    rd(4'h0, v); chk("R3 enable sticky", v, 32'h1);

    // R11 key with enable clear loads but does not arm
    do_reset();
    wr(4'h4, 32'h345);
    key(8'h55);
    rd(4'hC, v); chk("R11 loaded", v, 32'h345);
    repeat (40) @(negedge clk);
    rd(4'hC, v); chk("R11 holds unarmed", v, 32'h345);

    // R4/R6 step sweep on armed counter
    do_reset();
    wr(4'h0, 32'h1);
    tcs = '{32'hFF, 32'h1A7, 32'hFFFFFF};
    foreach (tcs[t]) begin
      wr(4'h4, tcs[t]);
      for (int j = 0; j < 12; j++) begin
        key(8'h55);
        repeat (j) @(negedge clk);
        rd(4'hC, v);
        if (j == 0) chk("R4 load value", v, tcs[t]);
        else        chk("R6 count after j clocks", v, tcs[t] - 32'(j / 4));
      end
    end

    // R7 timeout with reset enabled
    do_reset();
    wr(4'h0, 32'h3);
    key(8'h55);
    first = -1; width = 0;
    for (int j = 1; j <= 1100; j++) begin
      @(negedge clk);
      if (wdg_rst_o) begin
        if (first < 0) first = j;
        width++;
      end
    end
    chk("R7 expiry cycle", first, 4 * 255);
    chk("R7 R12 pulse width", width, 1);
    rd(4'h0, v); chk("R7 flag set", v, 32'h7);
    rd(4'hC, v); chk("R6 count stops at zero", v, 32'h0);

    // R8 timeout without reset enable
    do_reset();
    wr(4'h0, 32'h1);
    key(8'h55);
    width = 0;
    for (int j = 0; j < 1100; j++) begin
      @(negedge clk);
      if (wdg_rst_o) width++;
    end
    chk("R8 no reset pulse", width, 0);
    rd(4'h0, v); chk("R8 flag only", v, 32'h5);

    // R9 malformed key, enabled
    do_reset();
    wr(4'h0, 32'h1);
    key(8'h12);
    chk("R9 reset after bad key", {31'b0, wdg_rst_o}, 32'h1);
    @(negedge clk);
    chk("R9 R12 one cycle", {31'b0, wdg_rst_o}, 32'h0);
    key(8'hAA);
    chk("R9 repeated first byte is bad", {31'b0, wdg_rst_o}, 32'h1);

    // R9 malformed key, not enabled
    do_reset();
    key(8'h12);
    chk("R9 disabled no reset", {31'b0, wdg_rst_o}, 32'h0);
    @(negedge clk);
    chk("R9 disabled still low", {31'b0, wdg_rst_o}, 32'h0);

    // R10 abandoned key
    do_reset();
    wr(4'h0, 32'h1);
    wr(4'h4, 32'h300);
    wr(4'h8, 32'hAA);
    rd(4'h0, v);
    wr(4'h8, 32'h55);
    chk("R10 no reset on abort by read", {31'b0, wdg_rst_o}, 32'h0);
    rd(4'hC, v); chk("R10 read aborts key", v, 32'hFFFFFF);
    wr(4'h8, 32'hAA);
    wr(4'h4, 32'h300);
    wr(4'h8, 32'h13);
    chk("R10 no reset on abort by write", {31'b0, wdg_rst_o}, 32'h0);
    rd(4'hC, v); chk("R10 write aborts key", v, 32'hFFFFFF);
    key(8'h55);
    rd(4'hC, v); chk("R10 fresh key works", v, 32'h300);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule